// File: doc/BRIEF.md
# DRAM Refresh Row Counter and Address Mux

This block sits between a processor and a DRAM array that needs eight row address bits. The processor issues refresh cycles in bus slots that it does not need for instruction work. It marks these slots by asserting a refresh strobe together with its memory-request strobe. The refresh address it supplies has too few bits to reach every row. The block therefore ignores that address and keeps its own row counter, which is wide enough for the whole array.

Both strobes are active low. They are brought into the system clock domain through a short synchronizer. When both synchronized strobes are low, the block raises a refresh flag. While the flag is high, it drives its counter onto the row address lines. At all other times the processor's row address bits pass straight through to those lines. When the refresh cycle ends, the counter steps to the next row, so successive refresh cycles visit every row in ascending order.

Top module: `dram_refresh_rowgen`

## Requirements
- R1: A refresh cycle is recognised only when `rfsh_n` and `mreq_n` are both low (active low). Each strobe passes through `SYNC_STAGES` (default 2) flops. `refresh_active` rises on the third rising clock edge after both strobes go low and stay low.
- R2: `refresh_active` stays high for as long as both strobes stay low. It falls on the third rising edge after either strobe returns high.
- R3: While `refresh_active` is high, `row_addr` equals the internal row counter and holds steady for the whole cycle.
- R4: While `refresh_active` is low, `row_addr` equals `cpu_addr[ROW_LSB+ROW_W-1:ROW_LSB]` (bits 7:0 by default). This path is combinational, with no clock of latency.
- R5: The counter advances by exactly one per refresh cycle, on the edge where `refresh_active` falls, however many clocks the strobes were held low. It does not change at any other time.
- R6: `rfsh_n` low with `mreq_n` high, or `mreq_n` low with `rfsh_n` high, is ignored. `refresh_active` stays low and the counter does not advance.
- R7: The counter wraps from 255 to 0.
- R8: The synchronous reset `rst`, held for at least two clocks, clears the counter to 0 and drives `refresh_active` low. Reset takes priority over a refresh cycle in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_addr | input | ADDR_W | Processor address bus |
| rfsh_n | input | 1 | Processor refresh strobe, active low |
| mreq_n | input | 1 | Processor memory-request strobe, active low |
| row_addr | output | ROW_W | Row address sent to the DRAM |
| refresh_active | output | 1 | High for the duration of a detected refresh cycle |

## Verification
Two events fall on the same clock edge: the end of a refresh cycle and the counter advance. At that edge the address mux must switch back to the processor address while the counter steps to the next row. The bench releases the strobes after holds of different lengths. On the sample after the falling edge of `refresh_active`, it checks that `row_addr` shows the processor bits and not the new count. The next refresh cycle must then present exactly one row higher. Reset is also asserted in the middle of an active refresh, to confirm that it overrides both the flag and the counter.

// File: rtl/dram_refresh_rowgen.sv
module dram_refresh_rowgen #(
  parameter int ADDR_W      = 16,
  parameter int ROW_W       = 8,
  parameter int ROW_LSB     = 0,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              rfsh_n,
  input  logic              mreq_n,
  output logic [ROW_W-1:0]  row_addr,
  output logic              refresh_active
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] rfsh_sync;
  logic [SYNC_STAGES-1:0] mreq_sync;
  logic [ROW_W-1:0]       row_cnt;
  logic                   active_q;
  logic                   slot_seen;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (rst) begin
          rfsh_sync <= '1;
          mreq_sync <= '1;
        end else begin
          rfsh_sync <= rfsh_n;
          mreq_sync <= mreq_n;
        end
      end
    end else begin : g_syncn
      always_ff @(posedge clk) begin
        if (rst) begin
          rfsh_sync <= '1;
          mreq_sync <= '1;
        end else begin
          rfsh_sync <= {rfsh_sync[SYNC_STAGES-2:0], rfsh_n};
          mreq_sync <= {mreq_sync[SYNC_STAGES-2:0], mreq_n};
        end
      end
    end
  endgenerate

  assign slot_seen = ~rfsh_sync[LAST] & ~mreq_sync[LAST];

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      row_cnt  <= '0;
    end else begin
      active_q <= slot_seen;
      if (active_q && !slot_seen)
        row_cnt <= row_cnt + 1'b1;
    end
  end

  assign refresh_active = active_q;
  assign row_addr = active_q ? row_cnt : cpu_addr[ROW_LSB +: ROW_W];

endmodule

// File: rtl/refresh_rowgen_chk.sv
module refresh_rowgen_chk #(
  parameter int ROW_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             refresh_active,
  input logic [ROW_W-1:0] row_addr,
  input logic [ROW_W-1:0] row_cnt
);

  p_reset_clear_r8: assert property (@(posedge clk)
    rst |=> (row_cnt == '0 && !refresh_active));

  p_single_step_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(refresh_active) |-> row_cnt == ROW_W'($past(row_cnt) + 1'b1));

  p_hold_count_r5: assert property (@(posedge clk) disable iff (rst)
    !$fell(refresh_active) |-> $stable(row_cnt));

  p_row_steady_r3: assert property (@(posedge clk) disable iff (rst)
    (refresh_active && $past(refresh_active)) |-> $stable(row_addr));

endmodule

bind dram_refresh_rowgen refresh_rowgen_chk #(.ROW_W(ROW_W)) u_chk (
  .clk(clk),
  .rst(rst),
  .refresh_active(refresh_active),
  .row_addr(row_addr),
  .row_cnt(row_cnt)
);

// File: tb/tb_dram_refresh_rowgen.sv
module tb_dram_refresh_rowgen;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = 16'h0;
  logic        rfsh_n = 1'b1;
  logic        mreq_n = 1'b1;
  logic [7:0]  row_addr;
  logic        refresh_active;

  int n_cmp = 0;
  int n_bad = 0;
  int exp_cnt = 0;

  always #2 clk = ~clk;

  dram_refresh_rowgen dut (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .rfsh_n(rfsh_n),
    .mreq_n(mreq_n), .row_addr(row_addr), .refresh_active(refresh_active)
  );

  // kind: 0 = both strobes, 1 = refresh strobe only, 2 = request strobe only
  localparam logic [29:0] VEC [8] = '{
    {2'd0, 4'd1, 16'h12A5, 8'h00},
    {2'd1, 4'd4, 16'h3C5A, 8'h5A},
    {2'd0, 4'd5, 16'hBEEF, 8'h01},
    {2'd2, 4'd3, 16'h0077, 8'h77},
    {2'd0, 4'd2, 16'hFFFF, 8'h02},
    {2'd0, 4'd8, 16'h8001, 8'h03},
    {2'd0, 4'd3, 16'h4242, 8'h04},
    {2'd1, 4'd1, 16'h00C3, 8'hC3}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic slot(input logic [1:0] kind, input int len, input logic [15:0] addr,
                      input logic [7:0] exp_row, input bit do_chk);
    @(negedge clk);
    cpu_addr = addr;
    rfsh_n = (kind == 2'd2);
    mreq_n = (kind == 2'd1);
    repeat (2) @(posedge clk);
    @(negedge clk);
    if (do_chk) chk(refresh_active == 1'b0, "R1 early", refresh_active, 0);
    @(posedge clk);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (do_chk) begin
        if (kind == 2'd0) begin
          chk(refresh_active == 1'b1, "R1/R2 active", refresh_active, 1);
          chk(row_addr == exp_row, "R3 row", row_addr, exp_row);
        end else begin
          chk(refresh_active == 1'b0, "R6 ignored flag", refresh_active, 0);
          chk(row_addr == exp_row, "R6 passthrough", row_addr, exp_row);
        end
      end
    end
    rfsh_n = 1'b1;
    mreq_n = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    if (do_chk && kind == 2'd0)
      chk(refresh_active == 1'b1, "R2 hold", refresh_active, 1);
    @(posedge clk);
    @(negedge clk);
    if (do_chk) begin
      chk(refresh_active == 1'b0, "R2 fall", refresh_active, 0);
      chk(row_addr == addr[7:0], "R4 after end", row_addr, addr[7:0]);
    end
    if (kind == 2'd0) exp_cnt = (exp_cnt + 1) % 256;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(refresh_active == 1'b0, "R8 reset flag", refresh_active, 0);
    rst = 1'b0;
    cpu_addr = 16'hA55A;
    #1 chk(row_addr == 8'h5A, "R4 pass", row_addr, 8'h5A);
    cpu_addr = 16'h5AC3;
    #1 chk(row_addr == 8'hC3, "R4 same cycle", row_addr, 8'hC3);

    foreach (VEC[k]) begin
      slot(VEC[k][29:28], int'(VEC[k][27:24]), VEC[k][23:8], VEC[k][7:0], 1'b1);
    end
    slot(2'd0, 1, 16'h0000, 8'(exp_cnt), 1'b1);  // R6: skipped slots left the count at 5

    // R8: reset during an active refresh, strobes still low
    @(negedge clk);
    rfsh_n = 1'b0;
    mreq_n = 1'b0;
    repeat (4) @(negedge clk);
    chk(refresh_active == 1'b1, "R8 pre", refresh_active, 1);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(refresh_active == 1'b0, "R8 flag cleared", refresh_active, 0);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk(refresh_active == 1'b1 && row_addr == 8'h00, "R8 count cleared", row_addr, 0);
    rfsh_n = 1'b1;
    mreq_n = 1'b1;
    repeat (4) @(negedge clk);
    exp_cnt = 1;

    // R7: walk to 255, then wrap
    for (int j = 0; j < 254; j++) slot(2'd0, 1, 16'h0101, 8'h00, 1'b0);
    slot(2'd0, 2, 16'h1234, 8'hFF, 1'b1);
    chk(exp_cnt == 0, "R7 model", exp_cnt, 0);
    slot(2'd0, 1, 16'h4321, 8'h00, 1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    n_cmp++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule